// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Multiplexer

This block gathers a small group of level-sensitive interrupt sub-sources (two to fifteen, set by a parameter) behind a single summary line. That line feeds one fixed input of a primary interrupt controller. The raw levels appear in a read-only status register. A separate per-bit mask register gates them, and in that register a 1 disables a sub-source. The summary line is high while any sub-source is both pending and enabled. The interrupt service routine reads both registers, keeps the bits that are pending and not masked, and services each one as a level interrupt.

One sub-source, chosen by a parameter, can be tied to an external device whose interrupt latch needs an explicit clear. When software mask-acknowledges that sub-source, the block emits a one-cycle clear strobe toward the device. A mask-acknowledge is a mask write that sets its bit while the acknowledge qualifier is high. The status and mask registers sit at separate, parameterised offsets on a simple register bus. Reads are combinational and writes take effect on the clock edge.

Top module: `irq_submux`

## Requirements
- R1: The status register samples the sub-source inputs on every clock edge. A read at the status offset returns the value of the inputs before the most recent edge in bits [N_SRC-1:0], with zeros above.
- R2: A write to the status offset changes neither the status register nor the mask register.
- R3: After reset the mask register reads all ones in bits [N_SRC-1:0], the summary output is low, and the clear strobe is low.
- R4: A write at the mask offset loads bits [N_SRC-1:0] of the write data into the mask register on that edge, and a read at the mask offset returns it.
- R5: The summary output is 1 exactly when some bit is 1 in the status register and 0 in the mask register (a mask bit of 1 disables that sub-source).
- R6: A read at any offset other than the status and mask offsets returns zero, and a write there changes no register.
- R7: A mask write that takes bit CLR_IDX from 0 to 1 while the acknowledge qualifier is high drives the clear strobe high for exactly the one cycle that follows that edge.
- R8: No clear strobe is produced when the acknowledge qualifier is low, when bit CLR_IDX is already 1 before the write, or when the write leaves that bit at 0.
- R9: A sub-source held high and unmasked keeps the summary output high. The summary output falls one edge after that input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Level-sensitive sub-source requests |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write enable for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ack_qual_i | input | 1 | Marks a mask write as a mask-acknowledge |
| summary_o | output | 1 | Summary request to the primary controller |
| ext_clr_o | output | 1 | One-cycle clear strobe toward the external device |

## Verification
The clear strobe is the hardest case to reach. It needs bit CLR_IDX to be clear first, which only an earlier unmasking write can arrange, and then a write that sets that bit in the same cycle as the acknowledge qualifier. Random mask writes toggle every bit often, and the acknowledge qualifier is randomised on its own, so all four combinations of previous bit value and qualifier occur many times. Directed sequences then force a set while the bit is already set, a set with the qualifier low, and two consecutive acknowledging writes, to confirm that the strobe never stretches beyond one cycle.

// File: rtl/irq_submux.sv
module irq_submux #(
  parameter int N_SRC    = 5,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int STAT_OFS = 'h150,
  parameter int MASK_OFS = 'h168,
  parameter bit CLR_EN   = 1'b1,
  parameter int CLR_IDX  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_qual_i,
  output logic              summary_o,
  output logic              ext_clr_o
);

  localparam int PAD_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] mask_q;

  wire hit_stat = (bus_addr == ADDR_W'(STAT_OFS));
  wire hit_mask = (bus_addr == ADDR_W'(MASK_OFS));
  wire mask_we  = bus_wr && hit_mask;
  wire unused_hi = ^bus_wdata[DATA_W-1:N_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= src_i;
      if (mask_we) mask_q <= bus_wdata[N_SRC-1:0];
    end
  end

  assign summary_o = |(status_q & ~mask_q);

  assign bus_rdata = hit_stat ? {{PAD_W{1'b0}}, status_q} :
                     hit_mask ? {{PAD_W{1'b0}}, mask_q}   : '0;

  generate
    if (CLR_EN) begin : g_clr
      logic clr_q;
      wire  ack_set = mask_we && ack_qual_i && bus_wdata[CLR_IDX] && !mask_q[CLR_IDX];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= ack_set;
      end
      assign ext_clr_o = clr_q;

      // R7
      clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr_o |=> !ext_clr_o);
      // R7
      clr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr_o |-> mask_q[CLR_IDX]);
      // R8
      clr_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !ack_qual_i) |=> !ext_clr_o);
    end else begin : g_noclr
      wire unused_ack = ack_qual_i;
      assign ext_clr_o = 1'b0;
    end
  endgenerate

  // R5
  sum_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> (status_q != '0) && (mask_q != '1));
  // R2
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_stat) |=> $stable(mask_q));
  // R6
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_stat && !hit_mask) |-> (bus_rdata == '0));
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

endmodule

// File: tb/irq_submux_tb.sv
`timescale 1ns/100ps
module irq_submux_tb_top;
  localparam int N = 5;
  localparam int CI = 1;
  localparam logic [11:0] A_ST = 12'h150;
  localparam logic [11:0] A_MK = 12'h168;
  localparam logic [11:0] A_UN = 12'h154;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic [11:0] bus_addr = A_UN;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ack_qual_i = 1'b0;
  logic summary_o, ext_clr_o;

  int total = 0;
  int bad = 0;
  logic [N-1:0] e_mask, e_stat;
  logic e_clr;

  always #2.5 clk = ~clk;

  irq_submux dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_qual_i(ack_qual_i), .summary_o(summary_o), .ext_clr_o(ext_clr_o)
  );

  function automatic logic f_sum(input logic [N-1:0] st, input logic [N-1:0] mk);
    return |(st & ~mk);
  endfunction

  function automatic logic f_clr(input logic wr, input logic [11:0] a,
                                 input logic ack, input logic [31:0] wd,
                                 input logic [N-1:0] mk);
    return wr && (a == A_MK) && ack && wd[CI] && !mk[CI];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, model, then check just after posedge.
  task automatic cyc(input logic [N-1:0] s, input logic wr, input logic [11:0] a,
                     input logic [31:0] wd, input logic ack, input string tag);
    @(negedge clk);
    src_i = s; bus_wr = wr; bus_addr = a; bus_wdata = wd; ack_qual_i = ack;
    e_clr = f_clr(wr, a, ack, wd, e_mask);
    if (wr && a == A_MK) e_mask = wd[N-1:0];
    e_stat = s;
    @(posedge clk);
    #0.4;
    bus_wr = 1'b0; ack_qual_i = 1'b0;
    chk({tag, " R7/R8 clr"}, 32'(ext_clr_o), 32'(e_clr));
    chk({tag, " R5/R9 summary"}, 32'(summary_o), 32'(f_sum(e_stat, e_mask)));
    bus_addr = A_ST; #0.4;
    chk({tag, " R1 status"}, bus_rdata, 32'(e_stat));
    bus_addr = A_MK; #0.4;
    chk({tag, " R4 mask"}, bus_rdata, 32'(e_mask));
    bus_addr = A_UN; #0.4;
    chk({tag, " R6 unmapped"}, bus_rdata, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    e_mask = '1; e_stat = '0; e_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    bus_addr = A_MK; #0.2;
    chk("R3 mask reset", bus_rdata, 32'(5'h1F));
    chk("R3 summary reset", 32'(summary_o), 32'h0);
    chk("R3 clr reset", 32'(ext_clr_o), 32'h0);
    rst_n = 1'b1;

    cyc(5'h1F, 1'b0, A_UN, 32'h0, 1'b0, "R3 masked sources");
    cyc(5'h04, 1'b1, A_MK, 32'h1B, 1'b0, "R5 unmask bit2");
    cyc(5'h04, 1'b1, A_ST, 32'h0, 1'b1, "R2 status write");
    cyc(5'h04, 1'b1, A_UN, 32'h00, 1'b1, "R6 unmapped write");
    cyc(5'h04, 1'b0, A_UN, 32'h0, 1'b0, "R9 level hold");
    cyc(5'h00, 1'b0, A_UN, 32'h0, 1'b0, "R9 level drop");
    cyc(5'h00, 1'b1, A_MK, 32'h00, 1'b0, "R4 unmask all");
    cyc(5'h02, 1'b1, A_MK, 32'h02, 1'b0, "R8 no ack");
    cyc(5'h02, 1'b1, A_MK, 32'h00, 1'b0, "R4 reopen");
    cyc(5'h02, 1'b1, A_MK, 32'hFFFFFF02, 1'b1, "R7 mask-ack");
    cyc(5'h02, 1'b1, A_MK, 32'h02, 1'b1, "R8 already set");
    cyc(5'h02, 1'b1, A_MK, 32'h05, 1'b1, "R8 other bits");
    cyc(5'h02, 1'b1, A_MK, 32'h00, 1'b0, "R4 reopen2");
    cyc(5'h02, 1'b1, A_MK, 32'h02, 1'b1, "R7 pulse");
    cyc(5'h02, 1'b0, A_UN, 32'h0, 1'b0, "R7 pulse end");

    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] s;
      logic wr, ack;
      logic [11:0] a;
      logic [31:0] wd;
      int pick;
      s = N'($urandom);
      wr = $urandom_range(0, 3) != 0;
      pick = $urandom_range(0, 5);
      a = (pick < 4) ? A_MK : (pick == 4) ? A_ST : A_UN;
      wd = $urandom;
      ack = $urandom_range(0, 1);
      cyc(s, wr, a, wd, ack, "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule